// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is a slave on a two-wire serial bus (clock line plus bidirectional open-drain data line). It sits in front of a byte-wide RAM whose writes finish at once, so there is no busy interval and no page buffer. A fast system clock oversamples both bus lines. Each line goes through a two-flop synchronizer and a glitch filter, and edges, start conditions and stop conditions are found on the filtered levels. The block answers to a four-bit device type of `1010` plus three select bits that come from input pins.

A write transaction loads a two-byte memory pointer, high byte first, and then stores any number of data bytes at ascending addresses. A read transaction streams bytes from the pointer for as long as the master keeps acknowledging. The pointer keeps its value from one transaction to the next. A write that only loads the pointer, followed by a repeated start and a read, therefore gives a random read. A write-protect input blocks all data stores. The data line is driven through an active-high pull-low enable.

The pointer width is the parameter `ADDR_W`. A value of 13 gives an 8192-byte map. The default of 12 keeps the elaborated array at 4096 bytes. The control FSM has these states:
- `ST_IDLE`: not addressed.
- `ST_DEV`: shifting in the device byte.
- `ST_ADRH` and `ST_ADRL`: shifting in the pointer bytes.
- `ST_WDAT`: shifting in data.
- `ST_ACK_WAIT`: the 8th clock is high and the acknowledge is pending.
- `ST_ACK_DRV`: the 9th clock, with the line held low.
- `ST_TX_BIT`: sending a data bit.
- `ST_TX_ACK`: the 9th clock of a read, sampling the master's acknowledge.

A start moves any state to `ST_DEV`, and a stop moves any state to `ST_IDLE`. The other transitions are:
- `ST_DEV` goes to `ST_ACK_WAIT` on a match and to `ST_IDLE` on a mismatch.
- Each receive state goes to `ST_ACK_WAIT` after 8 bits. With write-protect high, `ST_WDAT` goes to `ST_IDLE` instead.
- `ST_ACK_WAIT` goes to `ST_ACK_DRV` on a falling clock edge.
- `ST_ACK_DRV` goes to its return state, which is one of `ST_ADRH`, `ST_ADRL`, `ST_WDAT` or `ST_TX_BIT`.
- `ST_TX_BIT` goes to `ST_TX_ACK` after 8 bits.
- `ST_TX_ACK` goes to `ST_TX_BIT` after an acknowledge and to `ST_IDLE` after a no-acknowledge.

Top module: `tw_mem_slave`

## Requirements
- R1: The device byte (first byte after a start, MSB first) is acknowledged only when its bits 7..4 are `1010` and its bits 3..1 equal `dev_sel_i`. Otherwise the slave leaves the data line released until the next start, and any later bytes are neither acknowledged nor acted on.
- R2: In a write (device byte bit 0 = 0) the next two bytes set the pointer, high byte first. Only the low `ADDR_W-8` bits of the high byte are used; its upper bits are ignored.
- R3: Every byte the slave accepts is acknowledged by pulling the data line low for the whole 9th clock.
- R4: A data byte is stored when its 8th bit is sampled. A start or stop before the 8th bit leaves memory unchanged.
- R5: The pointer advances by one after each stored or sent byte and wraps from all-ones to zero. A transaction may carry any number of bytes.
- R6: While `wp_i` is high, data bytes get no acknowledge, are not stored, and do not advance the pointer. Pointer bytes are still accepted.
- R7: A read (device byte bit 0 = 1) starts at the current pointer, and the pointer keeps its value across transactions.
- R8: During a read, a master acknowledge (data low in the 9th clock) starts the next byte. A no-acknowledge ends the read with the line released.
- R9: A start aborts any operation and waits for a device byte, so a repeated start after the pointer bytes gives a random read. A stop returns the slave to idle with the line released.
- R10: The slave changes the line only while the clock line is low, and samples the line on rising clock edges.
- R11: A clock pulse shorter than `FILT_LEN` system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| dev_sel_i | input | 3 | Device select bits compared with device byte bits 3..1 |
| wp_i | input | 1 | Write protect, high blocks data stores |
| sda_pull_o | output | 1 | High pulls the data line low |

## Verification
The hardest situations to reach from the ports are an abort partway through a data byte and a write attempt under protection. In both cases the outcome is visible only through later memory contents or the pointer position. The bench sends half a data byte and then issues a repeated start straight into a read, which shows that the location kept its old value. It also reads back after a refused write, which shows both that nothing was stored and that the pointer did not move. A one-clock spike on the clock line in the middle of a byte checks the filter, and pointer loads near the top of the map exercise the wrap.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADRH,
        ST_ADRL,
        ST_WDAT,
        ST_ACK_WAIT,
        ST_ACK_DRV,
        ST_TX_BIT,
        ST_TX_ACK
    } tw_state_t;
endpackage

// File: rtl/tw_deglitch.sv
module tw_deglitch #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            lvl_o  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == lvl_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                cnt_q <= '0;
                lvl_o <= sync_q[1];
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f_i;
            sda_q <= sda_f_i;
        end
    end

    assign rise_o  = scl_f_i & ~scl_q;
    assign fall_o  = ~scl_f_i & scl_q;
    assign start_o = scl_f_i & scl_q & sda_q & ~sda_f_i;
    assign stop_o  = scl_f_i & scl_q & ~sda_q & sda_f_i;
endmodule

// File: rtl/tw_ram.sv
module tw_ram #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[addr_i];
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
    import tw_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [2:0]        dev_sel_i,
    input  logic              wp_i,
    input  logic [7:0]        rdata_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              sda_pull_o
);
    localparam int HI_W = ADDR_W - 8;

    tw_state_t         state_q, state_d, ret_q;
    logic [2:0]        bit_q;
    logic [6:0]        rx_q;
    logic [7:0]        tx_q;
    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              rd_q, mack_q, ack_q, tx_en_q;
    logic [7:0]        byte_in;
    logic              last, byte_done, dev_hit;

    assign byte_in   = {rx_q, sda_lvl_i};
    assign last      = (bit_q == 3'd7);
    assign byte_done = rise_i & last;
    assign dev_hit   = (byte_in[7:4] == DEV_TYPE) && (byte_in[3:1] == dev_sel_i);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_DEV;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_DEV:      if (byte_done) state_d = dev_hit ? ST_ACK_WAIT : ST_IDLE;
                ST_ADRH,
                ST_ADRL:     if (byte_done) state_d = ST_ACK_WAIT;
                ST_WDAT:     if (byte_done) state_d = wp_i ? ST_IDLE : ST_ACK_WAIT;
                ST_ACK_WAIT: if (fall_i) state_d = ST_ACK_DRV;
                ST_ACK_DRV:  if (fall_i) state_d = ret_q;
                ST_TX_BIT:   if (fall_i && last) state_d = ST_TX_ACK;
                ST_TX_ACK:   if (fall_i) state_d = mack_q ? ST_TX_BIT : ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // receive path, pointer and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            rx_q   <= '0;
            hi_q   <= '0;
            ptr_q  <= '0;
            rd_q   <= 1'b0;
            mack_q <= 1'b0;
            ret_q  <= ST_IDLE;
        end else if (start_i || stop_i) begin
            bit_q <= '0;
        end else begin
            unique case (state_q)
                ST_DEV, ST_ADRH, ST_ADRL, ST_WDAT: begin
                    if (rise_i) begin
                        rx_q  <= byte_in[6:0];
                        bit_q <= bit_q + 3'd1;
                    end
                    if (byte_done) begin
                        unique case (state_q)
                            ST_DEV: begin
                                rd_q  <= byte_in[0];
                                ret_q <= byte_in[0] ? ST_TX_BIT : ST_ADRH;
                            end
                            ST_ADRH: begin
                                hi_q  <= byte_in[HI_W-1:0];
                                ret_q <= ST_ADRL;
                            end
                            ST_ADRL: begin
                                ptr_q <= {hi_q, byte_in};
                                ret_q <= ST_WDAT;
                            end
                            default: begin
                                if (!wp_i) ptr_q <= ptr_q + ADDR_W'(1);
                                ret_q <= ST_WDAT;
                            end
                        endcase
                    end
                end
                ST_TX_BIT: begin
                    if (fall_i) begin
                        bit_q <= bit_q + 3'd1;
                        if (last) ptr_q <= ptr_q + ADDR_W'(1);
                    end
                end
                ST_TX_ACK: begin
                    if (rise_i) mack_q <= ~sda_lvl_i;
                end
                default: ;
            endcase
        end
    end

    // outputs: acknowledge drive and transmit shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            tx_en_q <= 1'b0;
            tx_q    <= 8'hFF;
        end else if (start_i || stop_i || state_q == ST_IDLE) begin
            ack_q   <= 1'b0;
            tx_en_q <= 1'b0;
        end else if (fall_i) begin
            unique case (state_q)
                ST_ACK_WAIT: ack_q <= 1'b1;
                ST_ACK_DRV: begin
                    ack_q   <= 1'b0;
                    tx_en_q <= (ret_q == ST_TX_BIT);
                    tx_q    <= rdata_i;
                end
                ST_TX_BIT: begin
                    tx_q <= {tx_q[6:0], 1'b1};
                    if (last) tx_en_q <= 1'b0;
                end
                ST_TX_ACK: begin
                    tx_en_q <= mack_q;
                    tx_q    <= rdata_i;
                end
                default: ;
            endcase
        end
    end

    assign sda_pull_o  = ack_q | (tx_en_q & ~tx_q[7]);
    assign mem_we_o    = (state_q == ST_WDAT) && byte_done && !wp_i && !stop_i && !start_i;
    assign mem_addr_o  = ptr_q;
    assign mem_wdata_o = byte_in;

    // R9: a stop always leaves the line released
    a_r9_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !sda_pull_o);

    // R10: the drive changes only with the clock low (bus conditions excepted)
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull_o) || $fell(sda_pull_o)) |->
            (!$past(scl_lvl_i) || $past(start_i) || $past(stop_i)));

    // R6: a protected data byte leaves the pointer where it was
    a_r6_wp_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDAT && byte_done && wp_i && !start_i && !stop_i) |=> $stable(ptr_q));

    // R5: a store at the top address wraps the pointer to zero
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && ptr_q == '1) |=> (ptr_q == '0));

    // R1: when not addressed the line is never pulled
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_pull_o);

    // R8: a no-acknowledge ends the read
    a_r8_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX_ACK && fall_i && !mack_q && !start_i && !stop_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
    parameter int ADDR_W   = 12,
    parameter int FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic              rise, fall, start_ev, stop_ev;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wdata, rdata;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        tw_deglitch #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_lines[g]),
            .lvl_o (filt_lines[g])
        );
    end

    tw_bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f_i (filt_lines[1]),
        .sda_f_i (filt_lines[0]),
        .rise_o  (rise),
        .fall_o  (fall),
        .start_o (start_ev),
        .stop_o  (stop_ev)
    );

    tw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_lvl_i   (filt_lines[1]),
        .sda_lvl_i   (filt_lines[0]),
        .rise_i      (rise),
        .fall_i      (fall),
        .start_i     (start_ev),
        .stop_i      (stop_ev),
        .dev_sel_i   (dev_sel_i),
        .wp_i        (wp_i),
        .rdata_i     (rdata),
        .mem_we_o    (we),
        .mem_addr_o  (addr),
        .mem_wdata_o (wdata),
        .sda_pull_o  (sda_pull_o)
    );

    tw_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ram (
        .clk     (clk),
        .we_i    (we),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata)
    );
endmodule

// File: tb/tw_mem_slave_tb.sv
module tw_mem_slave_tb;
    localparam int AW = 12;
    localparam int Q  = 10;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_pull;
    wire  sda_bus = m_sda & ~sda_pull;

    int checks = 0, failures = 0;
    int r10_viol = 0, quiet_viol = 0;
    bit expect_quiet = 1'b0;
    bit done = 1'b0;
    logic prv_pull = 1'b0;

    logic [7:0] ref_mem [1 << AW];
    int ref_ptr = 0;

    always #2.5 clk = ~clk;

    tw_mem_slave #(.ADDR_W(AW), .FILT_LEN(3)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .dev_sel_i  (SEL),
        .wp_i       (wp),
        .sda_pull_o (sda_pull)
    );

    // per-clock comparison against the bench's expectation of the drive
    always @(posedge clk) begin
        if (rst_n) begin
            if (sda_pull !== prv_pull && m_scl) r10_viol++;
            if (expect_quiet && sda_pull) quiet_viol++;
        end
        prv_pull <= sda_pull;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        m_sda = 1'b1; wclk(Q);
        m_scl = 1'b1; wclk(2*Q);
        m_sda = 1'b0; wclk(2*Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic stop_c();
        m_sda = 1'b0; wclk(Q);
        m_scl = 1'b1; wclk(2*Q);
        m_sda = 1'b1; wclk(2*Q);
    endtask

    task automatic bit_c(input logic b, output logic s);
        m_sda = b;    wclk(Q);
        m_scl = 1'b1; wclk(Q);
        s = sda_bus;  wclk(Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit glitch, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_c(d[i], s);
            if (glitch && i == 4) begin
                m_scl = 1'b1; wclk(1); m_scl = 1'b0; wclk(Q);
            end
        end
        bit_c(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_c(1'b1, s);
            d[i] = s;
        end
        bit_c(~master_ack, s);
    endtask

    task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo);
        logic a;
        start_c();
        send_byte(DEV_W, 0, a); check("R1 device match ack", a, 1);
        send_byte(hi, 0, a);    check("R2 pointer high ack", a, 1);
        send_byte(lo, 0, a);    check("R2 pointer low ack", a, 1);
        ref_ptr = {hi[AW-9:0], lo};
    endtask

    task automatic wr_data(input logic [7:0] d);
        logic a;
        send_byte(d, 0, a);
        check("R3 data ack", a, 1);
        ref_mem[ref_ptr] = d;
        ref_ptr = (ref_ptr + 1) % (1 << AW);
    endtask

    task automatic rd_data(input bit more, input string req);
        logic [7:0] d;
        recv_byte(more, d);
        check(req, d, ref_mem[ref_ptr]);
        ref_ptr = (ref_ptr + 1) % (1 << AW);
    endtask

    task automatic cur_read1(input string req);
        logic a;
        start_c();
        send_byte(DEV_R, 0, a); check("R7 read device ack", a, 1);
        rd_data(0, req);
        check("R8 released after nack", sda_pull, 0);
        stop_c();
    endtask

    initial begin
        logic a, s;
        wclk(10);
        check("R9 reset drive released", sda_pull, 0);
        rst_n = 1'b1;
        wclk(10);

        // R2/R3/R5: multi-byte write with junk in the pointer's upper bits
        set_ptr(8'hF1, 8'h23);
        wr_data(8'h11); wr_data(8'h22); wr_data(8'h33); wr_data(8'h44); wr_data(8'h55);
        stop_c();

        // R9 random read via repeated start, R8 sequential reads
        set_ptr(8'h01, 8'h23);
        start_c();
        send_byte(DEV_R, 0, a); check("R9 repeated start read ack", a, 1);
        rd_data(1, "R8 seq byte0"); rd_data(1, "R8 seq byte1"); rd_data(0, "R8 seq byte2");
        stop_c();

        // R7 current address read continues at the kept pointer
        cur_read1("R7 current read 0x126");

        // R1 mismatched select and type: no ack, no action, line quiet
        start_c();
        expect_quiet = 1'b1;
        send_byte({4'b1010, 3'b010, 1'b0}, 0, a); check("R1 wrong select nack", a, 0);
        send_byte(8'h00, 0, a);                   check("R1 ignored byte nack", a, 0);
        send_byte(8'h00, 0, a);
        stop_c();
        start_c();
        send_byte({4'b1011, SEL, 1'b0}, 0, a);    check("R1 wrong type nack", a, 0);
        stop_c();
        expect_quiet = 1'b0;
        cur_read1("R1 pointer untouched 0x127");

        // R5 wrap on write and read
        set_ptr(8'h0F, 8'hFF);
        wr_data(8'h5A); wr_data(8'hC3);
        stop_c();
        check("R5 wrap ref pointer", ref_ptr, 1);
        set_ptr(8'h0F, 8'hFF);
        start_c();
        send_byte(DEV_R, 0, a);
        rd_data(1, "R5 read top"); rd_data(0, "R5 read wrapped zero");
        stop_c();

        // R6 write protect
        set_ptr(8'h02, 8'h00);
        wr_data(8'h55); wr_data(8'h66);
        stop_c();
        wp = 1'b1;
        set_ptr(8'h02, 8'h00);
        send_byte(8'h99, 0, a); check("R6 protected data nack", a, 0);
        stop_c();
        wp = 1'b0;
        cur_read1("R6 no store and no advance");

        // R4/R9 abort partway through a data byte
        set_ptr(8'h03, 8'h00);
        wr_data(8'h11);
        stop_c();
        set_ptr(8'h03, 8'h00);
        for (int i = 0; i < 4; i++) bit_c(1'b1, s);
        start_c();
        send_byte(DEV_R, 0, a); check("R9 start aborts byte", a, 1);
        rd_data(0, "R4 memory unchanged after abort");
        stop_c();

        // R11 short clock spike inside a byte
        set_ptr(8'h04, 8'h00);
        send_byte(8'hA5, 1, a); check("R11 byte with spike ack", a, 1);
        ref_mem[12'h400] = 8'hA5;
        stop_c();
        set_ptr(8'h04, 8'h00);
        start_c();
        send_byte(DEV_R, 0, a);
        rd_data(0, "R11 spike ignored");
        stop_c();

        check("R10 drive changed with clock high", r10_viol, 0);
        check("R1 line pulled while unaddressed", quiet_viol, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule